// File: doc/BRIEF.md
# Capture/Compare Timer

This block is a 16-bit peripheral timer that sits on a byte-wide register bus. A counter advances once per timebase tick and keeps running. An input-capture stage records the counter value when an external pin changes in the chosen direction. An output-compare stage raises an event when the counter sits on a programmed value, and it drives an output pin to a programmed level.

Three sticky event flags (overflow, compare, capture) share a control/status byte with five control bits. Each flag has its own interrupt request line. The overflow flag clears when software reads the status byte. The compare flag and the capture flag each clear only after a two-step access: a status read that saw the flag set, then an access to the matching data register. A 16-bit value is read high byte first. That read freezes the low byte, so the pair always belongs to one value.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset the counter reads 0. It advances by exactly one on each clock where `tick_i` is 1 and holds otherwise. Writes to offsets 0x09/0x0A do not change it.
- R2: A tick while the counter is 0xFFFF wraps it to 0 and sets the overflow flag, which is bit 5 of the status byte.
- R3: Control bit 1 selects the capture edge: 1 means rising, 0 means falling. The pin passes two synchroniser flops. On the third clock edge after the pin changes in the selected direction, the capture register takes the counter value. A change in the other direction leaves the capture register unchanged.
- R4: A capture sets the capture flag, which is status bit 7.
- R5: The compare register resets to 0xFFFF. A tick while the counter equals the compare register sets the compare flag, which is status bit 6.
- R6: On a compare match, the compare output pin takes the value of control bit 0. It holds that value between matches and resets to 0.
- R7: A status read clears the overflow flag. The compare flag clears on a write to 0x0B or 0x0C that follows a status read which saw it set. The capture flag clears on a read of 0x0D or 0x0E that follows a status read which saw it set. The data access alone does not clear a flag.
- R8: If a flag's event occurs on the same clock as the access that would clear it, the flag stays set.
- R9: The interrupt lines are the AND of a flag and its enable: overflow with control bit 2, compare with bit 3, capture with bit 4.
- R10: The status/control byte sits at 0x08 and reads as {capture flag, compare flag, overflow flag, control[4:0]}. Writes change only control bits 4:0. The 16-bit registers are counter 0x09/0x0A, compare 0x0B/0x0C and capture 0x0D/0x0E, each with the high byte at the lower offset. An unmapped offset reads 0.
- R11: Reading the high byte of the counter or the capture register latches its low byte. The low offset then returns the latched byte, even if the counter has moved on since.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase enable; counter advances when 1 |
| cap_pin_i | input | 1 | Asynchronous capture input |
| addr_i | input | ADDR_W | Register byte address |
| rd_en_i | input | 1 | Read strobe; side effects at the clock edge |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i`, combinational |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_cmp_o | output | 1 | Compare interrupt request |
| irq_cap_o | output | 1 | Capture interrupt request |
| cmp_pin_o | output | 1 | Compare output pin |

## Verification
The hardest case to reach is the collision in R8, where a compare event lands on the very edge that completes the clear sequence. The stimulus first sets the compare flag. It then points the compare register at the counter's current, stalled value and arms the clear with a status read. Finally it issues the clearing write in the same cycle as a single tick. Overflow needs the full 16-bit count. The bench computes the remaining tick count from its own counter model and runs exactly that many ticks, so the wrap lands on a known cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CTL_W  = 5;

    // control bit positions
    localparam int CTL_LVL    = 0;
    localparam int CTL_RISE   = 1;
    localparam int CTL_OVF_EN = 2;
    localparam int CTL_CMP_EN = 3;
    localparam int CTL_CAP_EN = 4;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // register index relative to the block base address
    typedef enum logic [2:0] {
        REG_CS     = 3'd0,
        REG_CNT_HI = 3'd1,
        REG_CNT_LO = 3'd2,
        REG_CMP_HI = 3'd3,
        REG_CMP_LO = 3'd4,
        REG_CAP_HI = 3'd5,
        REG_CAP_LO = 3'd6,
        REG_NONE   = 3'd7
    } reg_e;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic             ovf_flg;
        logic             cmp_flg;
        logic             cap_flg;
        logic             cmp_arm;
        logic             cap_arm;
        word_t            ocr;
        byte_t            cnt_lo_lat;
        byte_t            cap_lo_lat;
        logic             cmp_pin;
    } tmr_state_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick_i && (cnt_q == '1);

    // R1
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> cnt_o == $past(cnt_o) + W'(1));
    // R1
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int W      = 16,
    parameter int SYNC_N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         pin_i,
    input  logic         rise_sel_i,
    input  logic [W-1:0] cnt_i,
    output logic         evt_o,
    output logic [W-1:0] icr_o
);
    localparam int SH_W = SYNC_N + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
        logic [W-1:0]    icr;
    } cap_state_t;

    cap_state_t d, q;
    logic now_lvl, old_lvl;

    assign now_lvl = q.sh[SYNC_N-1];
    assign old_lvl = q.sh[SYNC_N];
    assign evt_o   = rise_sel_i ? (now_lvl && !old_lvl) : (!now_lvl && old_lvl);

    always_comb begin
        d    = q;
        d.sh = {q.sh[SH_W-2:0], pin_i};
        if (evt_o) begin
            d.icr = cnt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign icr_o = q.icr;

    // R3
    icr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |=> icr_o == $past(cnt_i));
    // R3
    icr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !evt_o |=> $stable(icr_o));
endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int BASE_ADDR = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              cap_pin_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              irq_ovf_o,
    output logic              irq_cmp_o,
    output logic              irq_cap_o,
    output logic              cmp_pin_o
);
    localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] N_REGS = ADDR_W'(7);

    tmr_state_t d, q;

    word_t cnt, icr;
    logic  wrap, cap_evt, cmp_hit;
    logic  [ADDR_W-1:0] off;
    reg_e  sel;
    logic  rd_cs, wr_ocr, rd_icr;

    tmr_counter #(.W(WORD_W)) u_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    tmr_capture #(.W(WORD_W), .SYNC_N(2)) u_capture (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (cap_pin_i),
        .rise_sel_i (q.ctl[CTL_RISE]),
        .cnt_i      (cnt),
        .evt_o      (cap_evt),
        .icr_o      (icr)
    );

    // address decode
    assign off = addr_i - BASE;
    assign sel = ((addr_i >= BASE) && (off < N_REGS)) ? reg_e'(off[2:0]) : REG_NONE;

    assign rd_cs   = rd_en_i && (sel == REG_CS);
    assign wr_ocr  = wr_en_i && ((sel == REG_CMP_HI) || (sel == REG_CMP_LO));
    assign rd_icr  = rd_en_i && ((sel == REG_CAP_HI) || (sel == REG_CAP_LO));
    assign cmp_hit = tick_i && (cnt == q.ocr);

    always_comb begin
        d = q;
        // register writes
        if (wr_en_i) begin
            case (sel)
                REG_CS:     d.ctl = wr_data_i[CTL_W-1:0];
                REG_CMP_HI: d.ocr[WORD_W-1:BYTE_W] = wr_data_i;
                REG_CMP_LO: d.ocr[BYTE_W-1:0] = wr_data_i;
                default:    ;
            endcase
        end
        // coherent read latches
        if (rd_en_i && (sel == REG_CNT_HI)) begin
            d.cnt_lo_lat = cnt[BYTE_W-1:0];
        end
        if (rd_en_i && (sel == REG_CAP_HI)) begin
            d.cap_lo_lat = icr[BYTE_W-1:0];
        end
        // clear sequencing
        if (rd_cs) begin
            d.ovf_flg = 1'b0;
            d.cmp_arm = q.cmp_flg;
            d.cap_arm = q.cap_flg;
        end
        if (wr_ocr && q.cmp_arm) begin
            d.cmp_flg = 1'b0;
            d.cmp_arm = 1'b0;
        end
        if (rd_icr && q.cap_arm) begin
            d.cap_flg = 1'b0;
            d.cap_arm = 1'b0;
        end
        // events take priority over clears
        if (wrap) begin
            d.ovf_flg = 1'b1;
        end
        if (cmp_hit) begin
            d.cmp_flg = 1'b1;
            d.cmp_pin = q.ctl[CTL_LVL];
        end
        if (cap_evt) begin
            d.cap_flg = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q     <= '0;
            q.ocr <= '1;
        end else begin
            q <= d;
        end
    end

    // read multiplexer
    always_comb begin
        case (sel)
            REG_CS:     rd_data_o = {q.cap_flg, q.cmp_flg, q.ovf_flg, q.ctl};
            REG_CNT_HI: rd_data_o = cnt[WORD_W-1:BYTE_W];
            REG_CNT_LO: rd_data_o = q.cnt_lo_lat;
            REG_CMP_HI: rd_data_o = q.ocr[WORD_W-1:BYTE_W];
            REG_CMP_LO: rd_data_o = q.ocr[BYTE_W-1:0];
            REG_CAP_HI: rd_data_o = icr[WORD_W-1:BYTE_W];
            REG_CAP_LO: rd_data_o = q.cap_lo_lat;
            default:    rd_data_o = '0;
        endcase
    end

    assign irq_ovf_o = q.ovf_flg && q.ctl[CTL_OVF_EN];
    assign irq_cmp_o = q.cmp_flg && q.ctl[CTL_CMP_EN];
    assign irq_cap_o = q.cap_flg && q.ctl[CTL_CAP_EN];
    assign cmp_pin_o = q.cmp_pin;

    // R2
    ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> q.ovf_flg);
    // R4
    cap_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_evt |=> q.cap_flg);
    // R5
    cmp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_hit |=> q.cmp_flg);
    // R6
    cmp_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_hit |=> cmp_pin_o == $past(q.ctl[CTL_LVL]));
    // R7
    cap_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.cap_flg && !q.cap_arm) |=> q.cap_flg);
    // R7
    cmp_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.cmp_flg && !q.cmp_arm) |=> q.cmp_flg);
endmodule

// File: tb/test_cap_cmp_timer.sv
module test_cap_cmp_timer;
    // delays in ns: 20 ns period, 50 MHz
    localparam logic [4:0] A_CS  = 5'h08;
    localparam logic [4:0] A_CNT = 5'h09;
    localparam logic [4:0] A_CMP = 5'h0B;
    localparam logic [4:0] A_CAP = 5'h0D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cap_pin = 1'b0;
    logic [4:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_ovf, irq_cmp, irq_cap, cmp_out;

    int n_chk  = 0;
    int n_fail = 0;
    int mcnt   = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cap_cmp_timer i_cap_cmp_timer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .cap_pin_i (cap_pin),
        .addr_i    (addr),
        .rd_en_i   (rd_en),
        .wr_en_i   (wr_en),
        .wr_data_i (wdata),
        .rd_data_o (rdata),
        .irq_ovf_o (irq_ovf),
        .irq_cmp_o (irq_cmp),
        .irq_cap_o (irq_cap),
        .cmp_pin_o (cmp_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] dv);
        addr  = a;
        rd_en = 1'b1;
        #2;
        dv = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] dv);
        addr  = a;
        wdata = dv;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd16(input logic [4:0] a, output logic [15:0] w);
        logic [7:0] h, l;
        rd(a, h);
        rd(a + 5'd1, l);
        w = {h, l};
    endtask

    task automatic wr16(input logic [4:0] a, input logic [15:0] w);
        wr(a, w[15:8]);
        wr(a + 5'd1, w[7:0]);
    endtask

    task automatic tk(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
        mcnt = mcnt + n;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int ecnt();
        return mcnt & 16'hFFFF;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        logic [15:0] tgt;
        logic        prev_pin;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // reset state
        rd(A_CS, b);      chk("R10 reset status", b, 8'h00);
        rd16(A_CNT, w);   chk("R1 reset counter", w, 16'h0000);
        rd16(A_CMP, w);   chk("R5 reset compare", w, 16'hFFFF);
        rd16(A_CAP, w);   chk("R3 reset capture", w, 16'h0000);
        chk("R9 reset irqs", {irq_ovf, irq_cmp, irq_cap}, 0);
        chk("R6 reset pin", cmp_out, 0);
        rd(5'h1F, b);     chk("R10 unmapped read", b, 0);

        // R1 counting, hold, write ignored
        tk(200);
        rd16(A_CNT, w);   chk("R1 count after ticks", w, ecnt());
        idle(7);
        rd16(A_CNT, w);   chk("R1 hold without tick", w, ecnt());
        wr(A_CNT, 8'hAA);
        wr(A_CNT + 5'd1, 8'h55);
        rd16(A_CNT, w);   chk("R1 write ignored", w, ecnt());

        // R11 coherent read: high byte latches low byte
        rd(A_CNT, b);
        w = 16'(ecnt());
        chk("R11 high byte", b, w[15:8]);
        tk(100);
        rd(A_CNT + 5'd1, b);
        chk("R11 latched low byte", b, w[7:0]);

        // R10 control bits only
        wr(A_CS, 8'hFF);
        rd(A_CS, b);      chk("R10 control write mask", b, 8'h1F);
        wr(A_CS, 8'h12);  // rising edge, capture irq enable
        rd(A_CS, b);      chk("R10 control readback", b, 8'h12);

        // R3/R4 rising capture
        cap_pin = 1'b1;
        idle(2);
        chk("R3 no capture before sync", irq_cap, 0);
        idle(1);
        chk("R4 capture flag irq", irq_cap, 1);
        rd16(A_CAP, w);   chk("R3 rising capture value", w, ecnt());
        chk("R7 capture read alone keeps flag", irq_cap, 1);
        rd(A_CS, b);      chk("R4 status bit7", b[7], 1);
        rd(A_CAP, b);
        chk("R7 capture flag cleared", irq_cap, 0);
        rd(A_CS, b);      chk("R7 status bit7 clear", b[7], 0);
        // falling edge with rising selected: ignored
        tgt = 16'(ecnt());
        tk(21);
        cap_pin = 1'b0;
        idle(4);
        chk("R3 opposite edge no flag", irq_cap, 0);
        rd16(A_CAP, w);   chk("R3 opposite edge value kept", w, tgt);
        // falling select
        wr(A_CS, 8'h10);
        tk(37);
        cap_pin = 1'b1;
        idle(4);
        chk("R3 rising ignored when falling selected", irq_cap, 0);
        tk(5);
        cap_pin = 1'b0;
        idle(3);
        chk("R4 falling capture flag", irq_cap, 1);
        rd16(A_CAP, w);   chk("R3 falling capture value", w, ecnt());
        wr(A_CS, 8'h00);
        chk("R9 capture irq masked", irq_cap, 0);
        rd(A_CS, b);      chk("R4 flag kept while masked", b[7], 1);
        rd(A_CAP, b);
        rd(A_CS, b);      chk("R7 capture clear sequence", b[7], 0);

        // R5/R6/R9 compare sweep over distances and levels
        prev_pin = 1'b0;
        for (int k = 0; k < 6; k++) begin
            logic lvl, en;
            lvl = k[0];
            en  = (k % 3) != 0;
            tgt = 16'(ecnt() + k);
            wr(A_CS, {4'b0, en, 2'b0, lvl});
            wr16(A_CMP, tgt);
            if (k > 0) tk(k);
            chk("R6 pin holds before match", cmp_out, prev_pin);
            chk("R5 no irq before match", irq_cmp, 0);
            tk(1);
            chk("R6 pin takes level", cmp_out, lvl);
            chk("R9 compare irq follows enable", irq_cmp, en);
            if (en) begin
                wr(A_CMP, tgt[15:8]);
                chk("R7 compare write alone keeps flag", irq_cmp, 1);
            end
            rd(A_CS, b);      chk("R5 status bit6", b[6], 1);
            wr(A_CMP, tgt[15:8]);
            rd(A_CS, b);      chk("R7 compare clear sequence", b[6], 0);
            prev_pin = lvl;
        end

        // R8 event coincides with the clearing write
        wr(A_CS, 8'h08);
        wr16(A_CMP, 16'(ecnt()));
        tk(1);
        chk("R5 compare hit for collision", irq_cmp, 1);
        tgt = 16'(ecnt());
        wr16(A_CMP, tgt);
        chk("R7 unarmed write keeps flag", irq_cmp, 1);
        rd(A_CS, b);
        tick = 1'b1;
        wr(A_CMP + 5'd1, tgt[7:0]);
        tick = 1'b0;
        mcnt = mcnt + 1;
        chk("R8 event wins over clear", irq_cmp, 1);
        rd(A_CS, b);
        wr(A_CMP, tgt[15:8]);
        chk("R7 clear after collision", irq_cmp, 0);

        // R2 overflow
        wr(A_CS, 8'h04);
        tk(65535 - ecnt());
        rd16(A_CNT, w);   chk("R2 counter at max", w, 16'hFFFF);
        chk("R2 no overflow yet", irq_ovf, 0);
        tk(1);
        chk("R9 overflow irq", irq_ovf, 1);
        rd16(A_CNT, w);   chk("R2 counter wrapped", w, 16'h0000);
        rd(A_CS, b);      chk("R2 status bit5", b[5], 1);
        chk("R7 status read clears overflow", irq_ovf, 0);
        rd(A_CS, b);      chk("R7 status bit5 clear", b[5], 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule